// File: doc/BRIEF.md
# I2C Slave Receiver with Clock Stretching

This block is a byte-oriented I2C slave that only receives. It samples SCL and SDA on the system clock and detects start and stop conditions and clock edges from those samples. It compares the first frame after each start against a 7-bit own address. When the address matches, it shifts in further bytes, one per nine-clock frame. The host chooses the level the slave drives in each acknowledge slot through a control input. That lets software NACK the final byte of a transfer.

After every received data byte the slave stretches the clock. It holds SCL low from the falling edge of the ninth clock until the host takes the byte with a read strobe. This gives a slow host unlimited time per byte without overrun. A status set reports the following: bus busy, a stop seen, an interrupt flag cleared only by software, a direction flag for read requests, and an optional address-hit indicator. Data transmission toward the master is not part of this block. A read request is acknowledged and flagged, and the slave then stays passive.

Top module: `i2c_slave_rx`

## Requirements
- R1: A start condition (SDA falling while SCL is high) sets `busy` and clears `stop_flag`. A stop condition (SDA rising while SCL is high) clears `busy` and sets `stop_flag`.
- R2: The first frame after a start carries the address MSB first in bits 1..7, followed by a R/W bit in position 8. On a match, R/W = 1 sets `dir_tx` and R/W = 0 leaves it 0. `dir_tx` is cleared at each start.
- R3: When the address does not match, the slave leaves SDA and SCL released and sets neither `rx_full` nor `irq_flag` for any frame until the next start.
- R4: In the ninth clock of every acknowledged frame, SDA is driven low when `ack_ctl` = 0 (ACK) and left released when `ack_ctl` = 1 (NACK).
- R5: At the rising edge of the ninth clock of a data frame, the received byte appears on `rx_data` and `rx_full` is set. `irq_flag` is set at the ninth clock of every addressed frame, and `irq` = `irq_flag` while `irq_en` = 1.
- R6: From the falling edge of the ninth clock of a data frame, SCL is held low while `rx_full` is 1. A one-cycle `rx_rd` pulse clears `rx_full` and releases SCL.
- R7: A stop condition sets `irq_flag` when `stop_mask` = 0 and leaves it unchanged when `stop_mask` = 1.
- R8: A matching address frame sets `addr_hit` when `match_en` = 1 and leaves it 0 when `match_en` = 0. It is cleared at each start.
- R9: `irq_flag` is cleared only by an `irq_clr` pulse. Reading data does not clear it.
- R10: After a matching address with R/W = 1 is acknowledged, the slave neither captures nor acknowledges further frames until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | Pulls SCL low when 1 (clock stretch) |
| sda_oe | output | 1 | Pulls SDA low when 1 (acknowledge) |
| own_addr | input | 7 | Own slave address |
| ack_ctl | input | 1 | Acknowledge level: 0 = ACK, 1 = NACK |
| irq_en | input | 1 | Interrupt request enable |
| stop_mask | input | 1 | 1 masks the stop interrupt |
| match_en | input | 1 | Enables the address-hit indicator |
| rx_rd | input | 1 | Host read strobe for the receive data |
| irq_clr | input | 1 | Clears the interrupt flag |
| rx_data | output | 8 | Received byte |
| rx_full | output | 1 | Receive data valid, not yet read |
| irq_flag | output | 1 | Interrupt flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Bus busy between start and stop |
| stop_flag | output | 1 | Stop seen since last start |
| dir_tx | output | 1 | Master requested a read |
| addr_hit | output | 1 | Address-match indicator |

## Verification
The assertions watch the following on every cycle:
- the acknowledge drive changes only while SCL is low;
- SCL is never stretched without a pending byte;
- `busy` and `stop_flag` are exclusive;
- `rx_data` changes only when `rx_full` rises, together with the interrupt flag;
- a host read always empties the buffer.

Only the bench scenarios can show the rest. These cover ACK versus NACK as seen by a master, the exact byte order delivered under stretching, suppression after an address mismatch or a read request, and the masking of the stop interrupt.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  // Per-cycle events derived from the synchronised bus lines
  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } bus_evt_t;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync
  import i2c_rx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_p, sda_p;
  logic              scl_s, sda_s;

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    evt.scl_rise = scl_s & ~scl_p;
    evt.scl_fall = ~scl_s & scl_p;
    evt.start    = scl_s & scl_p & sda_p & ~sda_s;
    evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
    evt.sda      = sda_s;
  end
endmodule

// File: rtl/i2c_rx_frame.sv
module i2c_rx_frame
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_ctl,
  input  logic              match_en,
  output logic              sda_drv,
  output logic              dir_tx,
  output logic              addr_hit,
  output logic              frame_done,
  output logic              byte_done,
  output logic              ninth_fall,
  output logic [DATA_W-1:0] byte_out
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              listen_q, listen_d;
  logic              addr_ph_q, addr_ph_d;
  logic              drv_q, drv_d;
  logic              dir_q, dir_d;
  logic              hit_q, hit_d;
  logic              match;

  assign match = (sh_q[DATA_W-1 -: ADDR_W] == own_addr);

  always_comb begin
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    listen_d   = listen_q;
    addr_ph_d  = addr_ph_q;
    drv_d      = drv_q;
    dir_d      = dir_q;
    hit_d      = hit_q;
    frame_done = 1'b0;
    byte_done  = 1'b0;
    ninth_fall = 1'b0;
    if (evt.start) begin
      cnt_d     = '0;
      listen_d  = 1'b1;
      addr_ph_d = 1'b1;
      drv_d     = 1'b0;
      dir_d     = 1'b0;
      hit_d     = 1'b0;
    end else if (evt.stop) begin
      listen_d = 1'b0;
      drv_d    = 1'b0;
    end else if (listen_q) begin
      if (evt.scl_rise) begin
        if (cnt_q < LAST_BIT) begin
          sh_d  = {sh_q[DATA_W-2:0], evt.sda};
          cnt_d = cnt_q + 1'b1;
        end else if (cnt_q == LAST_BIT) begin
          cnt_d      = ACK_BIT;
          frame_done = 1'b1;
          byte_done  = ~addr_ph_q;
        end
      end else if (evt.scl_fall) begin
        if (cnt_q == LAST_BIT) begin
          if (addr_ph_q) begin
            if (match) begin
              drv_d = ~ack_ctl;
              dir_d = sh_q[0];
              hit_d = match_en;
            end else begin
              listen_d = 1'b0;
            end
          end else begin
            drv_d = ~ack_ctl;
          end
        end else if (cnt_q == ACK_BIT) begin
          drv_d      = 1'b0;
          cnt_d      = '0;
          ninth_fall = ~addr_ph_q;
          addr_ph_d  = 1'b0;
          if (addr_ph_q && sh_q[0]) listen_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      listen_q  <= 1'b0;
      addr_ph_q <= 1'b0;
      drv_q     <= 1'b0;
      dir_q     <= 1'b0;
      hit_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      listen_q  <= listen_d;
      addr_ph_q <= addr_ph_d;
      drv_q     <= drv_d;
      dir_q     <= dir_d;
      hit_q     <= hit_d;
    end
  end

  assign sda_drv  = drv_q;
  assign dir_tx   = dir_q;
  assign addr_hit = hit_q;
  assign byte_out = sh_q;
endmodule

// File: rtl/i2c_rx_host.sv
module i2c_rx_host #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              frame_done,
  input  logic              byte_done,
  input  logic              ninth_fall,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              rx_rd,
  input  logic              irq_clr,
  input  logic              stop_mask,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              hold,
  output logic              irq_flag,
  output logic              busy,
  output logic              stop_flag
);
  logic full_d, hold_d, irq_d, busy_d, stop_d;
  logic data_en;

  assign data_en = byte_done;

  always_comb begin
    busy_d = busy;
    stop_d = stop_flag;
    if (start_evt) begin
      busy_d = 1'b1;
      stop_d = 1'b0;
    end else if (stop_evt) begin
      busy_d = 1'b0;
      stop_d = 1'b1;
    end
    irq_d = irq_flag;
    if (irq_clr) irq_d = 1'b0;
    if (frame_done || (stop_evt && !stop_mask)) irq_d = 1'b1;
    full_d = rx_full;
    if (rx_rd) full_d = 1'b0;
    if (byte_done) full_d = 1'b1;
    hold_d = hold;
    if (rx_rd) hold_d = 1'b0;
    else if (ninth_fall && rx_full) hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      stop_flag <= 1'b0;
      irq_flag  <= 1'b0;
      rx_full   <= 1'b0;
      hold      <= 1'b0;
    end else begin
      busy      <= busy_d;
      stop_flag <= stop_d;
      irq_flag  <= irq_d;
      rx_full   <= full_d;
      hold      <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_data <= '0;
    else if (data_en) rx_data <= byte_in;
  end
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_ctl,
  input  logic              irq_en,
  input  logic              stop_mask,
  input  logic              match_en,
  input  logic              rx_rd,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              irq_flag,
  output logic              irq,
  output logic              busy,
  output logic              stop_flag,
  output logic              dir_tx,
  output logic              addr_hit
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  bus_evt_t          evt;
  logic              frame_done, byte_done, ninth_fall, hold;
  logic [DATA_W-1:0] byte_w;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i), .evt(evt)
  );

  i2c_rx_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_core_n), .evt(evt), .own_addr(own_addr),
    .ack_ctl(ack_ctl), .match_en(match_en), .sda_drv(sda_oe),
    .dir_tx(dir_tx), .addr_hit(addr_hit), .frame_done(frame_done),
    .byte_done(byte_done), .ninth_fall(ninth_fall), .byte_out(byte_w)
  );

  i2c_rx_host #(.DATA_W(DATA_W)) u_host (
    .clk(clk), .rst_n(rst_core_n), .start_evt(evt.start), .stop_evt(evt.stop),
    .frame_done(frame_done), .byte_done(byte_done), .ninth_fall(ninth_fall),
    .byte_in(byte_w), .rx_rd(rx_rd), .irq_clr(irq_clr), .stop_mask(stop_mask),
    .rx_data(rx_data), .rx_full(rx_full), .hold(hold), .irq_flag(irq_flag),
    .busy(busy), .stop_flag(stop_flag)
  );

  assign scl_oe = hold;
  assign irq    = irq_flag & irq_en;
endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              scl_oe,
  input logic              rx_full,
  input logic              rx_rd,
  input logic [DATA_W-1:0] rx_data,
  input logic              irq_flag,
  input logic              busy,
  input logic              stop_flag
);
  // R4
  ack_drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R6
  stretch_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> rx_full);

  // R6
  read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_full) |=> !rx_full);

  // R1
  busy_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag |-> !busy);

  // R5
  data_with_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> $rose(rx_full));

  // R5
  full_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> irq_flag);
endmodule

bind i2c_slave_rx i2c_slave_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .rx_full(rx_full), .rx_rd(rx_rd), .rx_data(rx_data), .irq_flag(irq_flag),
  .busy(busy), .stop_flag(stop_flag)
);

// File: tb/i2c_slave_rx_test.sv
module i2c_slave_rx_test;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl_low, m_sda_low;
  logic       scl_bus, sda_bus;
  logic       scl_oe, sda_oe;
  logic [6:0] own_addr;
  logic       ack_ctl, irq_en, stop_mask, match_en, rx_rd, irq_clr;
  logic [7:0] rx_data;
  logic       rx_full, irq_flag, irq, busy, stop_flag, dir_tx, addr_hit;

  int         checks = 0;
  int         fails  = 0;
  bit         ended  = 0;
  logic [7:0] expq[$];

  always #5 clk = ~clk;

  assign scl_bus = !(m_scl_low || scl_oe);
  assign sda_bus = !(m_sda_low || sda_oe);

  i2c_slave_rx uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .ack_ctl(ack_ctl),
    .irq_en(irq_en), .stop_mask(stop_mask), .match_en(match_en),
    .rx_rd(rx_rd), .irq_clr(irq_clr), .rx_data(rx_data), .rx_full(rx_full),
    .irq_flag(irq_flag), .irq(irq), .busy(busy), .stop_flag(stop_flag),
    .dir_tx(dir_tx), .addr_hit(addr_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic put_bit(input logic b, output logic seen);
    m_sda_low = !b;
    repeat (Q) @(negedge clk);
    m_scl_low = 1'b0;
    wait (scl_bus == 1'b1);
    repeat (Q) @(negedge clk);
    seen = sda_bus;
    m_scl_low = 1'b1;
    repeat (Q) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic dummy;
    for (int i = 7; i >= 0; i--) put_bit(v[i], dummy);
    put_bit(1'b1, ack);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0;
    m_scl_low = 1'b0;
    wait (scl_bus == 1'b1);
    repeat (Q) @(negedge clk);
    m_sda_low = 1'b1;
    repeat (Q) @(negedge clk);
    m_scl_low = 1'b1;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1;
    repeat (Q) @(negedge clk);
    m_scl_low = 1'b0;
    wait (scl_bus == 1'b1);
    repeat (Q) @(negedge clk);
    m_sda_low = 1'b0;
    repeat (Q) @(negedge clk);
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops the scoreboard when a byte is delivered, then reads it
  initial begin
    rx_rd = 1'b0;
    forever begin
      wait (rx_full == 1'b1);
      repeat (60) @(negedge clk);
      check("R6 stretch drive", scl_oe, 1'b1);
      check("R6 scl held", scl_bus, 1'b0);
      if (expq.size() == 0) begin
        check("R5 unexpected byte", rx_data, 32'hFFFF);
      end else begin
        check("R5 byte", rx_data, expq.pop_front());
      end
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
      check("R6 read clears full", rx_full, 1'b0);
      @(negedge clk);
      check("R6 read releases", scl_oe, 1'b0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic ack;
    rst_n = 1'b0;
    m_scl_low = 1'b0; m_sda_low = 1'b0;
    own_addr = 7'h2A; ack_ctl = 1'b0; irq_en = 1'b1; stop_mask = 1'b0;
    match_en = 1'b1; irq_clr = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 reset busy", busy, 1'b0);
    check("R1 reset stop", stop_flag, 1'b0);
    check("R6 reset scl_oe", scl_oe, 1'b0);
    check("R4 reset sda_oe", sda_oe, 1'b0);
    check("R5 reset full", rx_full, 1'b0);
    check("R9 reset irq", irq_flag, 1'b0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // Addressed write with three data bytes
    bus_start();
    check("R1 start busy", busy, 1'b1);
    check("R1 start stop clr", stop_flag, 1'b0);
    send_byte({7'h2A, 1'b0}, ack);
    check("R4 address ack", ack, 1'b0);
    check("R2 write dir", dir_tx, 1'b0);
    check("R8 hit", addr_hit, 1'b1);
    check("R5 addr irq flag", irq_flag, 1'b1);
    check("R5 irq out", irq, 1'b1);
    pulse_clr();
    check("R9 clear", irq_flag, 1'b0);
    expq.push_back(8'hA5);
    send_byte(8'hA5, ack);
    check("R4 data ack", ack, 1'b0);
    check("R5 data irq flag", irq_flag, 1'b1);
    expq.push_back(8'h3C);
    send_byte(8'h3C, ack);
    check("R4 data ack 2", ack, 1'b0);
    wait (rx_full == 1'b0);
    repeat (5) @(negedge clk);
    check("R9 read keeps irq", irq_flag, 1'b1);
    ack_ctl = 1'b1;
    expq.push_back(8'h81);
    send_byte(8'h81, ack);
    check("R4 final nack", ack, 1'b1);
    pulse_clr();
    check("R9 clear 2", irq_flag, 1'b0);
    bus_stop();
    repeat (10) @(negedge clk);
    check("R1 stop busy", busy, 1'b0);
    check("R1 stop flag", stop_flag, 1'b1);
    check("R7 stop irq", irq_flag, 1'b1);
    pulse_clr();

    // Foreign address, stop masked
    stop_mask = 1'b1;
    ack_ctl = 1'b0;
    bus_start();
    check("R1 restart clears stop", stop_flag, 1'b0);
    send_byte({7'h15, 1'b0}, ack);
    check("R3 mismatch nack", ack, 1'b1);
    check("R3 no irq", irq_flag, 1'b0);
    send_byte(8'h5A, ack);
    check("R3 data ignored nack", ack, 1'b1);
    check("R3 no full", rx_full, 1'b0);
    check("R3 no stretch", scl_oe, 1'b0);
    bus_stop();
    repeat (10) @(negedge clk);
    check("R7 masked stop", irq_flag, 1'b0);
    check("R1 stop flag 2", stop_flag, 1'b1);

    // Read request, indicator disabled
    stop_mask = 1'b0;
    match_en = 1'b0;
    bus_start();
    send_byte({7'h2A, 1'b1}, ack);
    check("R10 read ack", ack, 1'b0);
    check("R2 read dir", dir_tx, 1'b1);
    check("R8 hit disabled", addr_hit, 1'b0);
    send_byte(8'h77, ack);
    check("R10 passive nack", ack, 1'b1);
    check("R10 no capture", rx_full, 1'b0);
    bus_stop();
    repeat (10) @(negedge clk);
    check("R5 scoreboard drained", expq.size(), 0);
    finish_run();
  end
endmodule